// File: doc/BRIEF.md
# Serial Clock Generator with Per-Select Clock Modes

This block derives the serial clock of a quad-SPI master from the fast functional clock. Software supplies two control words. The clock-control word carries a run-enable flag and a 16-bit divider. The device-control word carries one 8-bit mode lane for each chip select. While the transfer engine requests clocking and the enable flag is set, the block runs SCLK at the functional clock divided by (divider + 1). It also raises the line of the chosen chip select.

Each lane gives the idle level of the clock, the sampling phase and the active level of its chip-select pin. The lane that applies is chosen by the select index of the current command. The divider, the lane and the run decision are taken only at a period boundary or while idle, so a reconfiguration never cuts a clock pulse short. Along with SCLK, the transfer engine receives single-cycle launch and capture strobes, which are aligned with the cycle in which SCLK shows its new level.

Top module: `qspi_sclk_gen`

## Requirements
- R1: One SCLK period lasts P = divider+1 functional clock cycles (divider = clock-control bits 15:0). The leading edge (SCLK leaves its idle level) comes first, and the trailing edge follows floor(P/2) cycles later.
- R2: A divider value of 0 is treated as 1, so the shortest period is two functional clock cycles.
- R3: SCLK runs only while the enable flag (clock-control bit 31) and the transfer request are both high. When either drops, the current period completes and SCLK then rests at the idle level of the active lane.
- R4: A new divider, lane or run decision is taken only at a period boundary or while idle. A period that is already running keeps the divider it started with.
- R5: Lane n occupies device-control bits 8n+7..8n. Bit 8n is the idle clock level (1 = idle high), bit 8n+1 is the chip-select active level (1 = active high), and bit 8n+2 is the phase. Bits 8n+3..8n+7 have no effect on this block.
- R6: With phase 0, the capture strobe marks each leading edge and the launch strobe marks each trailing edge. With phase 1, the roles are swapped. Each strobe lasts one cycle and appears in the cycle in which SCLK first shows the new level.
- R7: Launch and capture are never high together. No strobe is issued while the clock is idle.
- R8: The selected chip-select pin shows its active level while clocking runs, and every other pin shows its inactive level. At most one select is active at a time.
- R9: After reset, SCLK is 0, both strobes are 0 and every chip-select pin is 1.
- R10: The chip select becomes active at the clock edge that accepts a request. The first leading edge of SCLK appears at the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clkctl_i | input | 32 | Clock-control word: bit 31 enable, bits 15:0 divider |
| devctl_i | input | 32 | Device-control word: four 8-bit mode lanes |
| cs_sel_i | input | 2 | Index of the chip select used by the current command |
| xfer_req_i | input | 1 | Transfer engine asks for clocking |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | One-cycle strobe at the edge where data is driven |
| capture_o | output | 1 | One-cycle strobe at the edge where data is sampled |
| cs_o | output | 4 | Chip-select pin levels, polarity applied per lane |

## Verification
The embedded assertions check on every cycle the properties that hold at any moment. These are: the two strobes are exclusive, SCLK rests at its idle level whenever clocking is stopped, every strobe coincides with a change of SCLK, the count stays inside the period, the divider is never zero, and at most one select is active. Only the bench scenarios can show the properties that span a whole transfer. These are the exact edge spacing for even, odd and clamped dividers, the role swap of the strobes across all four clock modes, a divider change taking effect only from the next period, a clean stop through the enable flag or through the request, and the per-lane chip-select polarity while the ignored lane bits are set.

// File: rtl/sclkgen_pkg.sv
package sclkgen_pkg;

   // One mode lane per chip select; field order is fixed by the device-control layout
   typedef struct packed {
      logic [4:0] dly;     // not used by the clock generator
      logic       cpha;    // lane bit 2
      logic       cspol;   // lane bit 1
      logic       cpol;    // lane bit 0
   } lane_cfg_t;

   localparam int unsigned LANE_W = $bits(lane_cfg_t);

endpackage

// File: rtl/sclk_lane_pick.sv
module sclk_lane_pick
   import sclkgen_pkg::*;
#(
   parameter int unsigned NUM_CS = 4,
   parameter int unsigned CTL_W  = 32,
   parameter int unsigned SEL_W  = 2
) (
   input  logic [CTL_W-1:0]  devctl_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic              cpol_o,
   output logic              cpha_o,
   output logic [NUM_CS-1:0] cspol_o
);

   localparam int unsigned USED_W = NUM_CS * LANE_W;

   lane_cfg_t         lanes [NUM_CS];
   logic [NUM_CS-1:0] unused_dly_bits;

   for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_lane
      assign lanes[gi]           = lane_cfg_t'(devctl_i[gi*LANE_W +: LANE_W]);
      assign cspol_o[gi]         = lanes[gi].cspol;
      assign unused_dly_bits[gi] = ^lanes[gi].dly;
   end

   if (CTL_W > USED_W) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^devctl_i[CTL_W-1:USED_W];
   end

   always_comb begin
      cpol_o = 1'b0;
      cpha_o = 1'b0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (sel_i == SEL_W'(i)) begin
            cpol_o = lanes[i].cpol;
            cpha_o = lanes[i].cpha;
         end
      end
   end

endmodule

// File: rtl/sclk_period_timer.sv
module sclk_period_timer #(
   parameter int unsigned DIV_W = 16,
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             req_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             running_o,
   output logic [DIV_W-1:0] cnt_o,
   output logic [DIV_W-1:0] div_o,
   output logic             bound_o,
   output logic             run_nx_o,
   output logic [SEL_W-1:0] sel_nx_o
);

   localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(1);

   logic             run_q;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] div_q;
   logic [SEL_W-1:0] sel_q;
   logic [DIV_W-1:0] div_clamped;
   logic             go;

   // a period boundary is the last cycle of a period, or any idle cycle
   assign bound_o     = !run_q || (cnt_q == div_q);
   assign go          = en_i && req_i;
   assign div_clamped = (div_i == '0) ? DIV_MIN : div_i;
   assign run_nx_o    = bound_o ? go : run_q;
   assign sel_nx_o    = bound_o ? sel_i : sel_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         div_q <= DIV_MIN;
         sel_q <= '0;
      end else if (bound_o) begin
         run_q <= go;
         cnt_q <= '0;
         div_q <= div_clamped;
         sel_q <= sel_i;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   assign running_o = run_q;
   assign cnt_o     = cnt_q;
   assign div_o     = div_q;

   // R1: the phase count never passes the end of the period it belongs to
   assert_cnt_in_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q |-> (cnt_q <= div_q));

   // R2: the held divider is never zero, whatever software wrote
   assert_div_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_q != '0);

   // R4: mid-period cycles leave the held divider untouched
   assert_div_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && (cnt_q != div_q)) |=> $stable(div_q));

endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [DIV_W-1:0] cnt_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             load_i,
   input  logic             cpol_i,
   input  logic             cpha_i,
   output logic             sclk_o,
   output logic             launch_o,
   output logic             capture_o
);

   logic             cpol_q;
   logic             cpha_q;
   logic             act_q;
   logic             launch_q;
   logic             capture_q;
   logic [DIV_W-1:0] half;
   logic             lead;
   logic             trail;

   // trailing edge sits floor((div+1)/2) cycles after the leading one
   assign half  = (div_i >> 1) + {{(DIV_W-1){1'b0}}, div_i[0]};
   assign lead  = run_i && (cnt_i == '0);
   assign trail = run_i && (cnt_i == half);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cpol_q    <= 1'b0;
         cpha_q    <= 1'b0;
         act_q     <= 1'b0;
         launch_q  <= 1'b0;
         capture_q <= 1'b0;
      end else begin
         if (load_i) begin
            cpol_q <= cpol_i;
            cpha_q <= cpha_i;
         end
         if (lead) begin
            act_q <= 1'b1;
         end else if (trail) begin
            act_q <= 1'b0;
         end
         launch_q  <= cpha_q ? lead : trail;
         capture_q <= cpha_q ? trail : lead;
      end
   end

   assign sclk_o    = cpol_q ^ act_q;
   assign launch_o  = launch_q;
   assign capture_o = capture_q;

   // R7: the two strobes never coincide
   assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(launch_q && capture_q));

   // R3: once stopped, the clock stays at the lane's idle level
   assert_idle_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |-> (sclk_o == cpol_q));

   // R6: every strobe appears together with a fresh SCLK level
   assert_strobe_on_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (launch_q || capture_q) |-> (sclk_o != $past(sclk_o)));

endmodule

// File: rtl/cs_pin_drive.sv
module cs_pin_drive #(
   parameter int unsigned NUM_CS = 4,
   parameter int unsigned SEL_W  = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_nx_i,
   input  logic [SEL_W-1:0]  sel_nx_i,
   input  logic [NUM_CS-1:0] cspol_i,
   output logic [NUM_CS-1:0] cs_o
);

   logic [NUM_CS-1:0] cs_q;
   logic [NUM_CS-1:0] act_q;

   for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_pin
      logic hit;
      assign hit = run_nx_i && (sel_nx_i == SEL_W'(gi));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cs_q[gi]  <= 1'b1;
            act_q[gi] <= 1'b0;
         end else begin
            cs_q[gi]  <= hit ? cspol_i[gi] : !cspol_i[gi];
            act_q[gi] <= hit;
         end
      end
   end

   assign cs_o = cs_q;

   // R8: never more than one select active
   assert_one_select_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(act_q));

endmodule

// File: rtl/qspi_sclk_gen.sv
module qspi_sclk_gen
   import sclkgen_pkg::*;
#(
   parameter int unsigned NUM_CS = 4,
   parameter int unsigned CTL_W  = 32,
   parameter int unsigned DIV_W  = 16,
   parameter int unsigned EN_BIT = 31,
   localparam int unsigned SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CTL_W-1:0]  clkctl_i,
   input  logic [CTL_W-1:0]  devctl_i,
   input  logic [SEL_W-1:0]  cs_sel_i,
   input  logic              xfer_req_i,
   output logic              sclk_o,
   output logic              launch_o,
   output logic              capture_o,
   output logic [NUM_CS-1:0] cs_o
);

   if (NUM_CS < 2) begin : g_bad_cs
      $error("qspi_sclk_gen: NUM_CS must be at least 2");
   end
   if (NUM_CS * LANE_W > CTL_W) begin : g_bad_lanes
      $error("qspi_sclk_gen: lanes do not fit the device-control word");
   end
   if (EN_BIT < DIV_W || EN_BIT >= CTL_W) begin : g_bad_en
      $error("qspi_sclk_gen: enable bit overlaps divider or lies outside the word");
   end

   logic              running;
   logic [DIV_W-1:0]  cnt;
   logic [DIV_W-1:0]  div_held;
   logic              bound;
   logic              run_nx;
   logic [SEL_W-1:0]  sel_nx;
   logic              lane_cpol;
   logic              lane_cpha;
   logic [NUM_CS-1:0] lane_cspol;
   logic              unused_clkctl;

   assign unused_clkctl = ^clkctl_i;

   sclk_period_timer #(
      .DIV_W (DIV_W),
      .SEL_W (SEL_W)
   ) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (clkctl_i[EN_BIT]),
      .req_i     (xfer_req_i),
      .div_i     (clkctl_i[DIV_W-1:0]),
      .sel_i     (cs_sel_i),
      .running_o (running),
      .cnt_o     (cnt),
      .div_o     (div_held),
      .bound_o   (bound),
      .run_nx_o  (run_nx),
      .sel_nx_o  (sel_nx)
   );

   sclk_lane_pick #(
      .NUM_CS (NUM_CS),
      .CTL_W  (CTL_W),
      .SEL_W  (SEL_W)
   ) u_lanes (
      .devctl_i (devctl_i),
      .sel_i    (cs_sel_i),
      .cpol_o   (lane_cpol),
      .cpha_o   (lane_cpha),
      .cspol_o  (lane_cspol)
   );

   sclk_edge_gen #(
      .DIV_W (DIV_W)
   ) u_edges (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (running),
      .cnt_i     (cnt),
      .div_i     (div_held),
      .load_i    (bound),
      .cpol_i    (lane_cpol),
      .cpha_i    (lane_cpha),
      .sclk_o    (sclk_o),
      .launch_o  (launch_o),
      .capture_o (capture_o)
   );

   cs_pin_drive #(
      .NUM_CS (NUM_CS),
      .SEL_W  (SEL_W)
   ) u_cs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_nx_i (run_nx),
      .sel_nx_i (sel_nx),
      .cspol_i  (lane_cspol),
      .cs_o     (cs_o)
   );

   // R7: while the clock is stopped the strobes stay quiet
   assert_no_idle_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!running && !$past(running)) |-> !(launch_o || capture_o));

endmodule

// File: tb/qspi_sclk_gen_tb_top.sv
module qspi_sclk_gen_tb_top;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      bit is_launch;
      bit lvl;
      int gap;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] clkctl = '0;
   logic [31:0] devctl = '0;
   logic [1:0]  cs_sel = '0;
   logic        xfer_req = 1'b0;
   logic        sclk;
   logic        launch;
   logic        capture;
   logic [3:0]  cs;

   int   n_chk = 0;
   int   n_fail = 0;
   int   cyc = 0;
   int   last_cyc = 0;
   bit   done = 1'b0;
   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   qspi_sclk_gen dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .clkctl_i   (clkctl),
      .devctl_i   (devctl),
      .cs_sel_i   (cs_sel),
      .xfer_req_i (xfer_req),
      .sclk_o     (sclk),
      .launch_o   (launch),
      .capture_o  (capture),
      .cs_o       (cs)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_cs(input int sel, input bit on);
      logic [3:0] v;
      for (int i = 0; i < 4; i++) begin
         v[i] = (on && i == sel) ? devctl[8*i+1] : !devctl[8*i+1];
      end
      return v;
   endfunction

   // monitor: pops expected edges as the design issues strobes
   always @(negedge clk) begin
      if (rst_n && (launch || capture)) begin
         chk(!(launch && capture), "R7", "both strobes", 1, 0);
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7", "unexpected strobe", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(launch == e.is_launch, "R6", "launch role", int'(launch), int'(e.is_launch));
            chk(sclk == e.lvl, "R6", "sclk level at strobe", int'(sclk), int'(e.lvl));
            if (e.gap >= 0) begin
               chk(cyc - last_cyc == e.gap, "R1", "edge spacing", cyc - last_cyc, e.gap);
            end
         end
         last_cyc = cyc;
      end
   end

   // driver: configures one lane, pushes the expected edges, runs the transfer
   task automatic run_xfer(input int sel, input bit cpol, input bit cpha, input bit cspol,
                           input logic [4:0] junk, input int div0, input int div1,
                           input int n, input bit stop_by_en);
      int p0, p1, h0, h1, total, pprev, hprev;
      p0 = ((div0 == 0) ? 1 : div0) + 1;
      p1 = ((div1 == 0) ? 1 : div1) + 1;
      h0 = p0 / 2;
      h1 = p1 / 2;
      total = p0 + (n - 1) * p1;
      @(negedge clk);
      devctl[8*sel +: 8] = {junk, cpha, cspol, cpol};
      cs_sel = 2'(sel);
      clkctl = {1'b1, 15'h0, 16'(div0)};
      repeat (2) @(negedge clk);
      chk(sclk == cpol, "R3", "idle level before start", int'(sclk), int'(cpol));
      chk(cs == exp_cs(sel, 1'b0), "R8", "cs idle", int'(cs), int'(exp_cs(sel, 1'b0)));
      pprev = 0;
      hprev = 0;
      for (int m = 0; m < n; m++) begin
         exp_t e;
         int p, h;
         p = (m == 0) ? p0 : p1;
         h = (m == 0) ? h0 : h1;
         e.is_launch = cpha;
         e.lvl = !cpol;
         e.gap = (m == 0) ? -1 : (pprev - hprev);
         exp_q.push_back(e);
         e.is_launch = !cpha;
         e.lvl = cpol;
         e.gap = h;
         exp_q.push_back(e);
         pprev = p;
         hprev = h;
      end
      xfer_req = 1'b1;
      for (int j = 1; j <= total; j++) begin
         @(negedge clk);
         if (j == 1) begin
            chk(cs == exp_cs(sel, 1'b1), "R10", "cs active after accept",
                int'(cs), int'(exp_cs(sel, 1'b1)));
            chk(!(launch || capture), "R10", "no edge yet", int'(launch | capture), 0);
         end
         if (j == 2) begin
            chk(launch || capture, "R10", "first leading edge", int'(launch | capture), 1);
            if (div1 != div0) clkctl[15:0] = 16'(div1);
         end
         if (j == total) begin
            if (stop_by_en) clkctl[31] = 1'b0;
            else            xfer_req = 1'b0;
         end
      end
      repeat (p1 + 6) @(negedge clk);
      chk(exp_q.size() == 0, "R3", "edges left after stop", exp_q.size(), 0);
      chk(sclk == cpol, "R3", "idle level after stop", int'(sclk), int'(cpol));
      chk(cs == exp_cs(sel, 1'b0), "R8", "cs released", int'(cs), int'(exp_cs(sel, 1'b0)));
      exp_q.delete();
      xfer_req = 1'b0;
      clkctl[31] = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(sclk == 1'b0, "R9", "sclk in reset", int'(sclk), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sclk == 1'b0, "R9", "sclk after reset", int'(sclk), 0);
      chk(!(launch || capture), "R9", "strobes after reset", int'(launch | capture), 0);
      chk(cs == 4'hF, "R9", "cs after reset", int'(cs), 15);
      // request without enable: nothing moves
      xfer_req = 1'b1;
      repeat (6) @(negedge clk);
      chk(cs == 4'hF, "R3", "no clocking without enable", int'(cs), 15);
      xfer_req = 1'b0;
      // mode 0, even period
      run_xfer(0, 1'b0, 1'b0, 1'b0, 5'h00, 3, 3, 3, 1'b0);
      // mode 1, odd period
      run_xfer(1, 1'b0, 1'b1, 1'b0, 5'h00, 4, 4, 2, 1'b0);
      // R2 R5: mode 2, zero divider clamped, active-high select, junk lane bits
      run_xfer(2, 1'b1, 1'b0, 1'b1, 5'h1F, 0, 0, 4, 1'b0);
      // R4: mode 3, divider changed mid-period, stopped through the enable flag
      run_xfer(3, 1'b1, 1'b1, 1'b0, 5'h0A, 2, 6, 3, 1'b1);
      // R4: shrinking divider, back on select 0
      run_xfer(0, 1'b0, 1'b1, 1'b0, 5'h15, 7, 1, 3, 1'b0);
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule